// File: doc/BRIEF.md
# Five-Level Hybrid-Clamped Leg PWM Generator

This block drives the fourteen gates of one leg of a five-level hybrid-clamped inverter. It uses level-shifted triangle carriers. A single up/down counter forms a triangle that runs from 0 to `SPAN` and back. Four carriers are built from it by adding fixed offsets, and together they cover the reference range from `-2*SPAN` to `+2*SPAN`. The signed reference sample is taken once per carrier period, at the valley. It is compared against every carrier. The four comparison results go to the four upper main switches in one of two redundant orders, and the order changes from one carrier period to the next. The four lower main gates are the complements of fixed upper partners. All six clamping gates follow the outermost upper switch.

A four-state machine controls the carrier phase and the order. `PH_RISE_A` counts up with the direct order. At the peak it moves to `PH_FALL_A`. When the count is about to reach zero, `PH_FALL_A` moves to `PH_RISE_B`, which counts up with the rotated order. `PH_RISE_B` moves to `PH_FALL_B` at the peak, and `PH_FALL_B` returns to `PH_RISE_A` at the valley. Reset puts the machine in `PH_RISE_A` with the count at zero. A sticky fault flag rises if any gate combination breaks the pairing or on-count rules.

Top module: `hc5_pwm_leg`

## Requirements
- R1: A synchronous active-high reset forces the bottom level: `gate_hi`=0000, `gate_lo`=1111 and `clamp`=010101 (bit 0 is Sc1). This state also holds on the first clock edge after reset is released.
- R2: After reset the shared counter takes the value `n mod 2*SPAN` on the n-th edge when that value is at most `SPAN`, and `2*SPAN` minus that value otherwise. Carrier k (0 at the top) equals the count plus `SPAN*(1-k)`. The gates are registered, so they reflect the counter value of the edge that loads them.
- R3: The switch order is direct in the first carrier period after reset and changes at every valley (count zero), so it alternates from period to period.
- R4: A comparison bit is 1 when the held reference is strictly greater than its carrier. In the direct order, carriers 0..3 drive `gate_hi` bits 0..3 (Sa1..Sa4). In the rotated order, carriers 0..3 drive bits 1, 2, 3, 0.
- R5: `gate_lo` bit 0 (Sa1') is the complement of Sa1. Bit 1 (Sa2') is the complement of Sa4. Bit 2 (Sa3') is the complement of Sa3. Bit 3 (Sa4') is the complement of Sa2.
- R6: When Sa1 is on, `clamp` is 101010 (Sc2, Sc4 and Sc6 on). When Sa1 is off, `clamp` is 010101, so Sc1 is always the complement of Sa1.
- R7: No two adjacent clamping gates (bits i and i+1) are ever on together.
- R8: Exactly four main gates and exactly three clamp gates are on in every cycle. The number of `gate_hi` bits set equals the number of carriers below the reference, and this gives the output level from 0 to 4.
- R9: `fault` is a sticky flag that only reset clears. It rises one cycle after a pairing, adjacency or on-count rule is broken, and it stays low in correct operation.
- R10: The reference is captured only at the valley. Changes to `ref_in` at any other time have no effect on the gates.
- R11: When the reference stays within ±`SPAN`, Sa1 never turns on in direct periods but does turn on in rotated periods, so it keeps switching at low modulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | DW | Signed reference sample, captured at the valley |
| gate_hi | output | 4 | Upper main gates, bit 0 = Sa1 … bit 3 = Sa4 |
| gate_lo | output | 4 | Lower main gates, bit 0 = Sa1' … bit 3 = Sa4' |
| clamp | output | 6 | Clamping gates, bit 0 = Sc1 … bit 5 = Sc6 |
| fault | output | 1 | Sticky gate-rule violation flag |

## Verification
The embedded assertions check these on every cycle: the complementary pairing, the clamp adjacency and on-count rules, the counter bound, the rule that the order changes only at a valley, the reference hold between valleys, the thermometer form of the comparisons and the reset state. Only the bench scenarios can show that the right carrier drives the right switch in each of the two orders, that mid-period changes to the reference are ignored, and that Sa1 keeps switching at low modulation only in rotated periods. To show these, the bench compares every gate output against a model built from the requirements, using random and held references and a reset in the middle of a run.

// File: rtl/hc5_pkg.sv
package hc5_pkg;

    typedef enum logic [1:0] {
        PH_RISE_A = 2'd0,
        PH_FALL_A = 2'd1,
        PH_RISE_B = 2'd2,
        PH_FALL_B = 2'd3
    } phase_e;

    typedef enum logic {
        ASG_DIRECT  = 1'b0,
        ASG_ROTATED = 1'b1
    } asg_e;

    localparam logic [5:0] CLAMP_ODD_ON  = 6'b010101;
    localparam logic [5:0] CLAMP_EVEN_ON = 6'b101010;

    typedef struct packed {
        logic [5:0] clamp;
        logic [3:0] lo;
        logic [3:0] hi;
    } gates_t;

endpackage

// File: rtl/hc5_carrier_fsm.sv
module hc5_carrier_fsm
    import hc5_pkg::*;
#(
    parameter int SPAN = 16,
    parameter int CW   = $clog2(SPAN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output asg_e          asg,
    output logic          valley
);

    localparam logic [CW-1:0] TOP = CW'(SPAN);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_RISE_A;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_RISE_A: begin
                if (cnt_q == TOP) begin
                    state_d = PH_FALL_A;
                    cnt_d   = cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_FALL_A: begin
                if (cnt_q == CW'(1)) begin
                    state_d = PH_RISE_B;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_RISE_B: begin
                if (cnt_q == TOP) begin
                    state_d = PH_FALL_B;
                    cnt_d   = cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_FALL_B: begin
                if (cnt_q == CW'(1)) begin
                    state_d = PH_RISE_A;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        cnt    = cnt_q;
        valley = (cnt_q == '0);
        unique case (state_q)
            PH_RISE_A, PH_FALL_A: asg = ASG_DIRECT;
            PH_RISE_B, PH_FALL_B: asg = ASG_ROTATED;
        endcase
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);

    // R3
    asg_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (asg != $past(asg)) |-> valley);

endmodule

// File: rtl/hc5_compare.sv
module hc5_compare #(
    parameter int DW   = 10,
    parameter int SPAN = 16,
    parameter int CW   = $clog2(SPAN + 1)
) (
    input  logic [CW-1:0]        cnt,
    input  logic signed [DW-1:0] ref_val,
    output logic [3:0]           above
);

    localparam int EW = DW + 1;

    logic signed [EW-1:0] ref_x;
    assign ref_x = EW'(ref_val);

    for (genvar k = 0; k < 4; k++) begin : g_car
        localparam int OFF = SPAN * (1 - k);
        logic signed [EW-1:0] carrier;
        assign carrier  = $signed(EW'(cnt)) + $signed(EW'(OFF));
        assign above[k] = (ref_x > carrier);
    end

endmodule

// File: rtl/hc5_gate_map.sv
module hc5_gate_map
    import hc5_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] above,
    input  asg_e       asg,
    output gates_t     gates
);

    gates_t g_d;

    always_comb begin
        g_d.hi = '0;
        unique case (asg)
            ASG_DIRECT:  g_d.hi = above;
            ASG_ROTATED: g_d.hi = {above[2], above[1], above[0], above[3]};
        endcase
        g_d.lo    = ~{g_d.hi[1], g_d.hi[2], g_d.hi[3], g_d.hi[0]};
        g_d.clamp = g_d.hi[0] ? CLAMP_EVEN_ON : CLAMP_ODD_ON;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gates.hi    <= '0;
            gates.lo    <= '1;
            gates.clamp <= CLAMP_ODD_ON;
        end else begin
            gates <= g_d;
        end
    end

    // R5
    pair_comp_chk: assert property (@(posedge clk) disable iff (rst)
        (gates.lo ^ {gates.hi[1], gates.hi[2], gates.hi[3], gates.hi[0]}) == 4'hF);

    // R7
    clamp_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        (gates.clamp[4:0] & gates.clamp[5:1]) == 5'd0);

    // R8
    on_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(gates.hi) + $countones(gates.lo) == 4) && ($countones(gates.clamp) == 3));

endmodule

// File: rtl/hc5_rule_mon.sv
module hc5_rule_mon
    import hc5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  gates_t gates,
    output logic   fault
);

    logic       viol;
    logic [3:0] main_on;
    logic [2:0] clamp_on;

    always_comb begin
        main_on  = '0;
        clamp_on = '0;
        for (int i = 0; i < 4; i++) begin
            main_on = main_on + 4'(gates.hi[i]) + 4'(gates.lo[i]);
        end
        for (int i = 0; i < 6; i++) begin
            clamp_on = clamp_on + 3'(gates.clamp[i]);
        end
        viol = ((gates.lo ^ {gates.hi[1], gates.hi[2], gates.hi[3], gates.hi[0]}) != 4'hF)
             || ((gates.clamp[4:0] & gates.clamp[5:1]) != 5'd0)
             || (gates.clamp[0] == gates.hi[0])
             || (main_on != 4'd4)
             || (clamp_on != 3'd3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault <= 1'b0;
        end else if (viol) begin
            fault <= 1'b1;
        end
    end

    // R9
    fault_low_chk: assert property (@(posedge clk) disable iff (rst)
        !fault);

endmodule

// File: rtl/hc5_pwm_leg.sv
module hc5_pwm_leg
    import hc5_pkg::*;
#(
    parameter int DW   = 10,
    parameter int SPAN = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] ref_in,
    output logic [3:0]           gate_hi,
    output logic [3:0]           gate_lo,
    output logic [5:0]           clamp,
    output logic                 fault
);

    localparam int CW = $clog2(SPAN + 1);
    localparam logic signed [DW-1:0] REF_FLOOR = {1'b1, {(DW-1){1'b0}}};

    logic [CW-1:0]        cnt;
    asg_e                 asg;
    logic                 valley;
    logic signed [DW-1:0] ref_q, ref_eff;
    logic [3:0]           above;
    gates_t               gates;

    hc5_carrier_fsm #(.SPAN(SPAN), .CW(CW)) i_fsm (
        .clk(clk), .rst(rst), .cnt(cnt), .asg(asg), .valley(valley)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= REF_FLOOR;
        end else if (valley) begin
            ref_q <= ref_in;
        end
    end

    assign ref_eff = valley ? ref_in : ref_q;

    hc5_compare #(.DW(DW), .SPAN(SPAN), .CW(CW)) i_cmp (
        .cnt(cnt), .ref_val(ref_eff), .above(above)
    );

    hc5_gate_map i_map (
        .clk(clk), .rst(rst), .above(above), .asg(asg), .gates(gates)
    );

    hc5_rule_mon i_mon (
        .clk(clk), .rst(rst), .gates(gates), .fault(fault)
    );

    assign gate_hi = gates.hi;
    assign gate_lo = gates.lo;
    assign clamp   = gates.clamp;

    // R1
    reset_safe_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gate_hi == 4'h0 && gate_lo == 4'hF && clamp == CLAMP_ODD_ON));

    // R10
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valley |=> $stable(ref_q));

    // R8
    cmp_thermo_chk: assert property (@(posedge clk) disable iff (rst)
        (above[2:0] & ~above[3:1]) == 3'd0);

    // R6
    clamp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        clamp[0] != gate_hi[0]);

endmodule

// File: tb/test_hc5_pwm_leg.sv
module test_hc5_pwm_leg;

    localparam int DW   = 10;
    localparam int SPAN = 16;
    localparam int PER  = 2 * SPAN;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [DW-1:0] ref_in = '0;
    logic [3:0]           gate_hi, gate_lo;
    logic [5:0]           clamp;
    logic                 fault;

    int checks = 0;
    int failures = 0;
    int n = 0;
    int pref = 0;
    int sa1_direct = 0;
    int sa1_rot = 0;

    always #5 clk = ~clk;

    hc5_pwm_leg #(.DW(DW), .SPAN(SPAN)) i_hc5_pwm_leg (
        .clk(clk), .rst(rst), .ref_in(ref_in),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .clamp(clamp), .fault(fault)
    );

    function automatic logic [13:0] model(int cnt, bit rot, int r);
        logic [3:0] c, hi, lo;
        logic [5:0] cl;
        for (int k = 0; k < 4; k++) c[k] = (r > cnt + SPAN * (1 - k));
        hi = rot ? {c[2], c[1], c[0], c[3]} : c;
        lo = {~hi[1], ~hi[2], ~hi[3], ~hi[0]};
        cl = hi[0] ? 6'b101010 : 6'b010101;
        return {cl, lo, hi};
    endfunction

    task automatic check(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s n=%0d actual=%b expected=%b", req, n, act, exp);
        end
    endtask

    task automatic step(string req, int r);
        int p, cnt;
        bit rot;
        logic [13:0] exp;
        p   = n % PER;
        cnt = (p <= SPAN) ? p : PER - p;
        rot = ((n / PER) % 2) == 1;
        ref_in = DW'(r);
        if (p == 0) pref = r;
        exp = model(cnt, rot, pref);
        @(negedge clk);
        check(req, {clamp, gate_lo, gate_hi}, exp);
        check("R9 fault", {13'd0, fault}, 14'd0);
        if (gate_hi[0]) begin
            if (rot) sa1_rot++;
            else     sa1_direct++;
        end
        n++;
    endtask

    task automatic do_reset(int cycles);
        @(negedge clk);
        rst = 1'b1;
        repeat (cycles) @(negedge clk);
        // R1 reset state
        check("R1 reset", {clamp, gate_lo, gate_hi}, {6'b010101, 4'hF, 4'h0});
        check("R1 fault clear", {13'd0, fault}, 14'd0);
        rst = 1'b0;
        n = 0;
    endtask

    function automatic int rnd_ref();
        return int'($urandom_range(0, 4 * SPAN + 8)) - (2 * SPAN + 4);
    endfunction

    initial begin
        #(10 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20061));
        do_reset(4);
        // R2 R3 R4 R5 R6 R8 R10: random reference changing every cycle
        for (int i = 0; i < 8 * PER; i++) step("R2 R3 R4 R10", rnd_ref());
        // R8 top level: reference above every carrier
        for (int i = 0; i < 2 * PER; i++) step("R8 top", (1 << (DW - 1)) - 1);
        // R8 bottom level: most negative reference
        for (int i = 0; i < 2 * PER; i++) step("R8 bottom", -(1 << (DW - 1)));
        // R4 boundary: reference equal to carrier peaks
        for (int i = 0; i < 2 * PER; i++) step("R4 equal", 2 * SPAN);
        for (int i = 0; i < 2 * PER; i++) step("R4 equal", -SPAN);
        // R11 low modulation
        sa1_direct = 0;
        sa1_rot = 0;
        for (int i = 0; i < 4 * PER; i++) step("R11 low", SPAN / 2);
        checks++;
        if (sa1_direct != 0) begin
            failures++;
            $display("FAIL R11 Sa1 in direct periods actual=%0d expected=0", sa1_direct);
        end
        checks++;
        if (sa1_rot == 0) begin
            failures++;
            $display("FAIL R11 Sa1 in rotated periods actual=0 expected>0");
        end
        // R1 reset in the middle of a period, then restart
        for (int i = 0; i < 7; i++) step("R2 pre", rnd_ref());
        do_reset(2);
        for (int i = 0; i < 4 * PER; i++) step("R3 R10 restart", rnd_ref());
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule